// File: doc/BRIEF.md
# Scan-Chain Debug Register Access Port

This block is a test-access data register. Through it an external debugger reads and writes a small bank of internal debug registers. The shift path holds a 32-bit data field, a 5-bit address field and a one-bit direction flag. An existing TAP state machine supplies single-cycle shift, capture and update strobes. These strobes are synchronous to the block clock, which is the test clock.

A write is one scan pass: the debugger sets the direction flag and the update strobe commits the data field into the addressed register. A read takes two passes. The first pass shifts in the address with the flag cleared. The capture at the start of the next pass loads that register into the data field. One register is a communications data register, which the core side fills through its own write port. A core-side fill sets bit 0 of a communications control register, which marks the data as valid. When the communications data register is read, the lowest address bit shifted out is replaced by this valid bit. The debugger therefore receives the data and its status in the same pass. A capture of the communications data register clears the valid bit.

All registers are visible to the rest of the chip on a flat output bus.

Top module: `dbgscan_port`

## Requirements
- R1: After reset every bank register holds zero, the shift path holds zero and tdo is 0.
- R2: Each cycle with shiftEn high moves the path one place toward tdo, and tdi enters at the direction-flag end. Path bit 0 (data LSB) is on tdo before the first shift. Bits 0..31 are data, 32..36 are address (LSB at 32) and bit 37 is the direction flag.
- R3: When updateEn is high, the direction flag is 1 and the address is implemented, the data field is written into that register on that clock edge.
- R4: Bank registers change only on an update write, a core-side write or the valid-bit clear described in R8. Shifting, capturing and update passes with the flag at 0 leave them unchanged.
- R5: When captureEn is high, the path loads the following: the register named by the address of the most recent update into the data field, that address into the address field, and 0 into the direction flag. Before any update, the captured address is 0.
- R6: When the captured address is the communications data register (address 5), address bit 32 of the path carries bit 0 of the communications control register (address 4) instead of the address LSB.
- R7: Addresses 8 to 31 are unimplemented. Writes to them change nothing, and a capture addressed to them loads zero data.
- R8: A coreWr pulse loads coreData into register 5 and sets bit 0 of register 4. A capture of register 5 clears that bit, unless coreWr is high in the same cycle, in which case the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tdi | input | 1 | Serial data in |
| shiftEn | input | 1 | Shift strobe from the TAP state machine |
| captureEn | input | 1 | Capture strobe |
| updateEn | input | 1 | Update strobe |
| coreWr | input | 1 | Core-side write of the communications data register |
| coreData | input | 32 | Core-side write data |
| tdo | output | 1 | Serial data out (path bit 0) |
| regsOut | output | 256 | Bank contents, register n at bits n*32 +: 32 |

## Verification
On every cycle, the assertions check the following: a single shift step, that the bank holds when no writer is active, that an update write lands, the status substitution in the captured address, zero data on an unimplemented capture, and how the valid bit is set and cleared. The captured address follows the last update, and the three strobes are mutually exclusive. The bench scenarios show the end-to-end behaviour that depends on a serial sequence: the bit order at tdo, write-then-readback across all 32 addresses, and the valid bit reading 1 and then 0 on consecutive communications reads.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;
  localparam int SCAN_ADDR_W = 5;

  typedef struct packed {
    logic                   doShift;
    logic                   doCapture;
    logic                   doWrite;
    logic                   rdValid;
    logic                   rdIsComms;
    logic [SCAN_ADDR_W-1:0] wrAddr;
    logic [SCAN_ADDR_W-1:0] rdAddr;
  } scanCtl_t;
endpackage

// File: rtl/dbgscan_ctrl.sv
module dbgscan_ctrl
  import dbgscan_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int DATA_ADDR = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   shiftEn,
  input  logic                   captureEn,
  input  logic                   updateEn,
  input  logic [SCAN_ADDR_W-1:0] scanAddr,
  input  logic                   scanWr,
  output scanCtl_t               ctl
);
  localparam logic [SCAN_ADDR_W:0]   NUM_L  = (SCAN_ADDR_W+1)'(NUM_REGS);
  localparam logic [SCAN_ADDR_W-1:0] DATA_A = SCAN_ADDR_W'(DATA_ADDR);

  logic [SCAN_ADDR_W-1:0] lastAddr;
  logic                   scanAddrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastAddr <= '0;
    else if (updateEn) lastAddr <= scanAddr;
  end

  assign scanAddrOk = ({1'b0, scanAddr} < NUM_L);

  always_comb begin
    ctl.doShift   = shiftEn;
    ctl.doCapture = captureEn;
    ctl.doWrite   = updateEn && scanWr && scanAddrOk;
    ctl.wrAddr    = scanAddr;
    ctl.rdAddr    = lastAddr;
    ctl.rdValid   = ({1'b0, lastAddr} < NUM_L);
    ctl.rdIsComms = (lastAddr == DATA_A);
  end

  // R2: the TAP state machine never raises two strobes together
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shiftEn, captureEn, updateEn}));

  // R5: the read address is taken from the address field at update
  a_r5_rdaddr_from_update: assert property (@(posedge clk) disable iff (!rstN)
    updateEn |=> ctl.rdAddr == $past(scanAddr));
endmodule

// File: rtl/dbgscan_dp.sv
module dbgscan_dp
  import dbgscan_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 8,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tdi,
  input  scanCtl_t                     ctl,
  input  logic                         coreWr,
  input  logic [DATA_W-1:0]            coreData,
  output logic [SCAN_ADDR_W-1:0]       scanAddr,
  output logic                         scanWr,
  output logic                         tdo,
  output logic [NUM_REGS*DATA_W-1:0]   regsOut
);
  localparam int SCAN_W = DATA_W + SCAN_ADDR_W + 1;
  localparam int A_LO   = DATA_W;
  localparam int A_HI   = DATA_W + SCAN_ADDR_W - 1;
  localparam int RW_B   = SCAN_W - 1;
  localparam int IDX_W  = $clog2(NUM_REGS);

  logic [SCAN_W-1:0]                scanQ;
  logic [NUM_REGS-1:0][DATA_W-1:0]  bankQ;
  logic [DATA_W-1:0]                rdData;
  logic [SCAN_ADDR_W-1:0]           capAddr;
  logic                             validBit;

  assign validBit = bankQ[CTRL_ADDR][0];
  assign rdData   = ctl.rdValid ? bankQ[ctl.rdAddr[IDX_W-1:0]] : '0;

  always_comb begin
    capAddr = ctl.rdAddr;
    if (ctl.rdIsComms) capAddr[0] = validBit;
  end

  // shift path: capture has priority, tdi enters at the flag end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanQ <= '0;
    else if (ctl.doCapture) scanQ <= {1'b0, capAddr, rdData};
    else if (ctl.doShift) scanQ <= {tdi, scanQ[SCAN_W-1:1]};
  end

  assign tdo      = scanQ[0];
  assign scanAddr = scanQ[A_HI:A_LO];
  assign scanWr   = scanQ[RW_B];

  // register bank; the core-side events are applied last and win
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bankQ <= '0;
    else begin
      for (int g = 0; g < NUM_REGS; g++) begin
        if (ctl.doWrite && ctl.wrAddr == SCAN_ADDR_W'(g))
          bankQ[g] <= scanQ[DATA_W-1:0];
        if (g == DATA_ADDR && coreWr)
          bankQ[g] <= coreData;
        if (g == CTRL_ADDR) begin
          if (ctl.doCapture && ctl.rdIsComms) bankQ[g][0] <= 1'b0;
          if (coreWr) bankQ[g][0] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regsOut[g*DATA_W +: DATA_W] = bankQ[g];
  end

  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doShift |=> scanQ[SCAN_W-2:0] == $past(scanQ[SCAN_W-1:1]));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doWrite && !coreWr |=>
      bankQ[$past(ctl.wrAddr[IDX_W-1:0])] == $past(scanQ[DATA_W-1:0]));

  a_r4_bank_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.doWrite && !coreWr && !(ctl.doCapture && ctl.rdIsComms) |=> $stable(bankQ));

  a_r5_capture_flag_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doCapture |=> !scanQ[RW_B]);

  a_r6_status_in_addr: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doCapture && ctl.rdIsComms |=> scanQ[A_LO] == $past(validBit));

  a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doCapture && !ctl.rdValid |=> scanQ[DATA_W-1:0] == '0);

  a_r8_valid_set: assert property (@(posedge clk) disable iff (!rstN)
    coreWr |=> validBit);

  a_r8_valid_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doCapture && ctl.rdIsComms && !coreWr |=> !validBit);
endmodule

// File: rtl/dbgscan_port.sv
module dbgscan_port
  import dbgscan_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 8,
  parameter int CTRL_ADDR = 4,
  parameter int DATA_ADDR = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tdi,
  input  logic                       shiftEn,
  input  logic                       captureEn,
  input  logic                       updateEn,
  input  logic                       coreWr,
  input  logic [DATA_W-1:0]          coreData,
  output logic                       tdo,
  output logic [NUM_REGS*DATA_W-1:0] regsOut
);
  scanCtl_t               ctl;
  logic [SCAN_ADDR_W-1:0] scanAddr;
  logic                   scanWr;

  dbgscan_ctrl #(
    .NUM_REGS (NUM_REGS),
    .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftEn  (shiftEn),
    .captureEn(captureEn),
    .updateEn (updateEn),
    .scanAddr (scanAddr),
    .scanWr   (scanWr),
    .ctl      (ctl)
  );

  dbgscan_dp #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tdi     (tdi),
    .ctl     (ctl),
    .coreWr  (coreWr),
    .coreData(coreData),
    .scanAddr(scanAddr),
    .scanWr  (scanWr),
    .tdo     (tdo),
    .regsOut (regsOut)
  );
endmodule

// File: tb/sim_dbgscan_port.sv
`timescale 1ns/1ps
module sim_dbgscan_port;
  localparam int NR = 8;
  localparam int CA = 4;
  localparam int DA = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tdi = 1'b0, shiftEn = 1'b0, captureEn = 1'b0, updateEn = 1'b0;
  logic coreWr = 1'b0;
  logic [31:0] coreData = '0;
  logic tdo;
  logic [NR*32-1:0] regsOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [31:0] mReg [32];
  int mLast = 0;

  always #4 clk = ~clk;

  dbgscan_port u0 (
    .clk(clk), .rstN(rstN), .tdi(tdi), .shiftEn(shiftEn), .captureEn(captureEn),
    .updateEn(updateEn), .coreWr(coreWr), .coreData(coreData), .tdo(tdo), .regsOut(regsOut)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  function automatic logic [NR*32-1:0] modelFlat();
    logic [NR*32-1:0] f;
    for (int g = 0; g < NR; g++) f[g*32 +: 32] = mReg[g];
    return f;
  endfunction

  function automatic logic [31:0] pat(input int a);
    return 32'h5A3C_0000 ^ (32'(a) * 32'h0103_0507);
  endfunction

  task automatic shiftOnly(input logic [37:0] inV, output logic [37:0] outV);
    for (int i = 0; i < 38; i++) begin
      outV[i] = tdo;
      tdi = inV[i];
      shiftEn = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    shiftEn = 1'b0;
  endtask

  // one full pass: capture, 38 shifts, update; checks the captured vector
  task automatic doPass(input logic rw, input int a, input logic [31:0] d);
    logic [37:0] inV, outV, expV;
    string tag;
    expV[31:0]  = (mLast < NR) ? mReg[mLast] : 32'h0;
    expV[36:32] = 5'(mLast);
    if (mLast == DA) expV[32] = mReg[CA][0];
    expV[37] = 1'b0;
    tag = (mLast >= NR) ? "R7" : ((mLast == DA) ? "R6" : "R5");
    if (mLast == DA) mReg[CA][0] = 1'b0;
    inV = {rw, 5'(a), d};
    captureEn = 1'b1;
    @(posedge clk); @(negedge clk);
    captureEn = 1'b0;
    shiftOnly(inV, outV);
    check(regsOut == modelFlat(), "R4 bank before update",
          $sformatf("%h", regsOut), $sformatf("%h", modelFlat()));
    updateEn = 1'b1;
    @(posedge clk); @(negedge clk);
    updateEn = 1'b0;
    check(outV == expV, tag, $sformatf("%h", outV), $sformatf("%h", expV));
    mLast = a;
    if (rw && a < NR) mReg[a] = d;
    check(regsOut == modelFlat(), (rw && a >= NR) ? "R7 write ignored" : (rw ? "R3" : "R4"),
          $sformatf("%h", regsOut), $sformatf("%h", modelFlat()));
  endtask

  task automatic coreWrite(input logic [31:0] d);
    coreData = d;
    coreWr = 1'b1;
    @(posedge clk); @(negedge clk);
    coreWr = 1'b0;
    mReg[DA] = d;
    mReg[CA][0] = 1'b1;
    check(regsOut == modelFlat(), "R8 core write",
          $sformatf("%h", regsOut), $sformatf("%h", modelFlat()));
  endtask

  initial begin
    logic [37:0] o1, o2;
    logic [37:0] p;
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(tdo == 1'b0, "R1 tdo", $sformatf("%b", tdo), "0");
    check(regsOut == '0, "R1 bank", $sformatf("%h", regsOut), "0");
    p = 38'h2A_9C31_E74B;
    shiftOnly(p, o1);
    check(o1 == '0, "R1 path", $sformatf("%h", o1), "0");
    shiftOnly('0, o2);
    check(o2 == p, "R2 order", $sformatf("%h", o2), $sformatf("%h", p));
    for (int a = 0; a < 32; a++) doPass(1'b1, a, pat(a));
    for (int a = 0; a < 32; a++) doPass(1'b0, a, ~pat(a));
    doPass(1'b0, 0, 32'h0);
    coreWrite(32'hCAFE_F00D);
    doPass(1'b0, DA, 32'h0);
    doPass(1'b0, DA, 32'h0);   // R6 valid bit reads 1, then R8 clears it
    doPass(1'b0, 0, 32'h0);    // R6 valid bit now reads 0
    check(regsOut[CA*32] == 1'b0, "R8 cleared", $sformatf("%b", regsOut[CA*32]), "0");
    doPass(1'b1, CA, 32'h0000_0001);
    doPass(1'b0, DA, 32'h0);
    doPass(1'b0, 0, 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule